// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is a circular buffer that keeps track of instructions in flight so that they may finish out of order but retire in program order. When an instruction is issued it takes the entry at the tail. The index of that entry is handed back as the instruction's tag. Later, a completion port names a tag and deposits the result value, an exception flag and a mispredict flag into that entry. Completion only records the result. No architectural state changes at that point.

Each cycle, commit logic looks only at the oldest entry, the head. A completed head entry of an ALU or load kind produces a register-file write. A completed store produces a memory write request. A correctly predicted branch just retires. If the head carries an exception, or is a mispredicted branch, the whole buffer is flushed and a restart is signalled, and the flush output tells the two cases apart. At most one entry retires per cycle. A lookup port lets an operand reader ask whether a tag has completed and read its value.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, `iss_ready` is 1, `iss_tag` is 0, and `rf_we`, `st_req` and `flush` are all 0.
- R2: An accepted issue returns the current tail index on `iss_tag`. Successive issues get consecutive tags that wrap from DEPTH-1 back to 0.
- R3: When DEPTH entries are occupied, `iss_ready` is 0 and an issue request is ignored. The next accepted issue after a slot frees receives the tag that follows the last accepted one.
- R4: A completion sets the entry's done flag and value, and `look_done`/`look_value` for that tag show this from the next cycle. Completion never asserts `rf_we` or `st_req` by itself.
- R5: Only the head entry retires, and only once it is done. A younger completed entry waits until every older entry has retired, and the head advances by one per retirement.
- R6: A retiring entry of kind ALU (`iss_kind`=0) or LOAD (`iss_kind`=1) asserts `rf_we` for one cycle, with `rf_addr` equal to its destination and `rf_data` equal to its result.
- R7: A retiring STORE (`iss_kind`=2) asserts `st_req` with `st_data` equal to its result, and `rf_we` stays 0. No store request is made before that commit.
- R8: A retiring BRANCH (`iss_kind`=3) without the mispredict flag frees its entry and asserts neither `rf_we` nor `st_req`.
- R9: A mispredicted BRANCH at the head raises `flush` with `flush_fault`=0. On the next cycle the buffer is empty, every tag reads as not done, and the tail is back at 0.
- R10: A head entry with its exception flag set raises `flush` with `flush_fault`=1 and no `rf_we` or `st_req`. Younger entries are discarded even if they have completed.
- R11: An issue and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| iss_dest | input | REG_W | Destination register |
| iss_ready | output | 1 | Buffer can accept an issue this cycle |
| iss_tag | output | TAG_W | Tag given to the issuing instruction (tail index) |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Entry being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_fault | input | 1 | Instruction raised an exception |
| cmp_misp | input | 1 | Branch was mispredicted |
| look_tag | input | TAG_W | Operand lookup tag |
| look_done | output | 1 | Looked-up entry is occupied and completed |
| look_value | output | DATA_W | Result of looked-up entry |
| rf_we | output | 1 | Register write at commit |
| rf_addr | output | REG_W | Register write address |
| rf_data | output | DATA_W | Register write data |
| st_req | output | 1 | Memory write request at commit |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Flush all entries and restart |
| flush_fault | output | 1 | 1 for exception flush, 0 for mispredict flush |
| empty | output | 1 | No occupied entries |

## Verification
Two pairs of functions can land in one cycle: an issue can coincide with a retirement, and a completion can coincide with a retirement. The first pair is provoked by presenting an issue in the very cycle the head commits. It is judged by the returned tag and by the buffer staying non-empty afterwards with the new tag not yet done. The second pair is provoked by completing a mispredicted branch while the entry ahead of it retires. It is judged by a correct register write in that cycle, followed by a mispredict flush on the next.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } kind_t;

  // Kinds that update the register file when they retire
  function automatic logic writes_reg(kind_t k);
    return (k == K_ALU) || (k == K_LOAD);
  endfunction
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_tail,
  input  logic             adv_head,
  input  logic             clear,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    if (p == TAG_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (adv_tail) tail <= bump(tail);
      if (adv_head) head <= bump(head);
      case ({adv_tail, adv_head})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  kind_t             alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              free_en,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_idx,
  input  logic [DATA_W-1:0] fill_value,
  input  logic              fill_fault,
  input  logic              fill_misp,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              head_busy,
  output logic              head_done,
  output kind_t             head_kind,
  output logic [REG_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_fault,
  output logic              head_misp,
  input  logic [TAG_W-1:0]  look_idx,
  output logic              look_done,
  output logic [DATA_W-1:0] look_value
);
  logic              busy_q  [DEPTH];
  logic              done_q  [DEPTH];
  logic              fault_q [DEPTH];
  logic              misp_q  [DEPTH];
  kind_t             kind_q  [DEPTH];
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        busy_q[i]  <= 1'b0;
        done_q[i]  <= 1'b0;
        fault_q[i] <= 1'b0;
        misp_q[i]  <= 1'b0;
        kind_q[i]  <= K_ALU;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end else if (clear) begin
        busy_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
      end else begin
        if (free_en && head_idx == TAG_W'(i)) busy_q[i] <= 1'b0;
        if (fill_en && fill_idx == TAG_W'(i) && busy_q[i]) begin
          done_q[i]  <= 1'b1;
          value_q[i] <= fill_value;
          fault_q[i] <= fill_fault;
          misp_q[i]  <= fill_misp;
        end
        if (alloc_en && alloc_idx == TAG_W'(i)) begin
          busy_q[i]  <= 1'b1;
          done_q[i]  <= 1'b0;
          fault_q[i] <= 1'b0;
          misp_q[i]  <= 1'b0;
          kind_q[i]  <= alloc_kind;
          dest_q[i]  <= alloc_dest;
        end
      end
    end
  end

  assign head_busy  = busy_q[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_kind  = kind_q[head_idx];
  assign head_dest  = dest_q[head_idx];
  assign head_value = value_q[head_idx];
  assign head_fault = fault_q[head_idx];
  assign head_misp  = misp_q[head_idx];

  assign look_done  = busy_q[look_idx] && done_q[look_idx];
  assign look_value = value_q[look_idx];
endmodule

// File: rtl/rob_commit.sv
module rob_commit
  import rob_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              head_busy,
  input  logic              head_done,
  input  kind_t             head_kind,
  input  logic [REG_W-1:0]  head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic              head_fault,
  input  logic              head_misp,
  output logic              retire,
  output logic              flush,
  output logic              flush_fault,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_req,
  output logic [DATA_W-1:0] st_data
);
  logic ready_head;
  logic bad_branch;

  assign ready_head  = head_busy && head_done;
  assign bad_branch  = (head_kind == K_BRANCH) && head_misp;
  assign flush       = ready_head && (head_fault || bad_branch);
  assign flush_fault = ready_head && head_fault;
  assign retire      = ready_head && !flush;
  assign rf_we       = retire && writes_reg(head_kind);
  assign st_req      = retire && (head_kind == K_STORE);
  assign rf_addr     = head_dest;
  assign rf_data     = head_value;
  assign st_data     = head_value;
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [REG_W-1:0]  iss_dest,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_fault,
  input  logic              cmp_misp,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_done,
  output logic [DATA_W-1:0] look_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_req,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic              flush_fault,
  output logic              empty
);
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              do_issue, do_commit;
  logic              head_busy, head_done, head_fault, head_misp;
  kind_t             head_kind;
  logic [REG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_value;

  assign iss_ready = !full && !flush;
  assign do_issue  = iss_valid && iss_ready;
  assign iss_tag   = tail;

  rob_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .adv_tail(do_issue), .adv_head(do_commit), .clear(flush),
    .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
  );

  rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .alloc_en(do_issue), .alloc_idx(tail), .alloc_kind(kind_t'(iss_kind)),
    .alloc_dest(iss_dest),
    .free_en(do_commit),
    .fill_en(cmp_valid), .fill_idx(cmp_tag), .fill_value(cmp_value),
    .fill_fault(cmp_fault), .fill_misp(cmp_misp),
    .head_idx(head), .head_busy(head_busy), .head_done(head_done),
    .head_kind(head_kind), .head_dest(head_dest), .head_value(head_value),
    .head_fault(head_fault), .head_misp(head_misp),
    .look_idx(look_tag), .look_done(look_done), .look_value(look_value)
  );

  rob_commit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_commit (
    .head_busy(head_busy), .head_done(head_done), .head_kind(head_kind),
    .head_dest(head_dest), .head_value(head_value),
    .head_fault(head_fault), .head_misp(head_misp),
    .retire(do_commit), .flush(flush), .flush_fault(flush_fault),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_req(st_req), .st_data(st_data)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full,
  input logic             empty,
  input logic             do_issue,
  input logic             do_commit,
  input logic             flush,
  input logic             rf_we,
  input logic             st_req,
  input logic             head_done,
  input logic [TAG_W-1:0] head,
  input logic [CNT_W-1:0] count
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !do_issue);

  p_commit_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || st_req) |-> head_done);

  p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> head == (($past(head) == TAG_W'(DEPTH - 1)) ? '0 : $past(head) + 1'b1));

  p_single_sink_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && st_req));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!rf_we && !st_req));

  p_occupancy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (do_issue && do_commit) |=> count == $past(count));
endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .empty(empty),
  .do_issue(do_issue), .do_commit(do_commit), .flush(flush),
  .rf_we(rf_we), .st_req(st_req), .head_done(head_done),
  .head(head), .count(count)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, TAG_W = 3;
  localparam logic [1:0] ALU = 2'd0, LOAD = 2'd1, STORE = 2'd2, BRANCH = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_kind = '0;
  logic [REG_W-1:0] iss_dest = '0;
  logic iss_ready;
  logic [TAG_W-1:0] iss_tag;
  logic cmp_valid = 1'b0, cmp_fault = 1'b0, cmp_misp = 1'b0;
  logic [TAG_W-1:0] cmp_tag = '0, look_tag = '0;
  logic [DATA_W-1:0] cmp_value = '0;
  logic look_done;
  logic [DATA_W-1:0] look_value, rf_data, st_data;
  logic rf_we, st_req, flush, flush_fault, empty;
  logic [REG_W-1:0] rf_addr;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_dest(iss_dest), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_fault(cmp_fault), .cmp_misp(cmp_misp), .look_tag(look_tag),
    .look_done(look_done), .look_value(look_value), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_data(rf_data), .st_req(st_req), .st_data(st_data),
    .flush(flush), .flush_fault(flush_fault), .empty(empty)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    iss_valid = 1'b0; cmp_valid = 1'b0; cmp_fault = 1'b0; cmp_misp = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [REG_W-1:0] d,
                       input logic [TAG_W-1:0] exp_tag, input string req);
    step();
    iss_valid = 1'b1; iss_kind = k; iss_dest = d;
    #2;
    chk({req, " ready"}, 32'(iss_ready), 1);
    chk({req, " tag"}, 32'(iss_tag), 32'(exp_tag));
  endtask

  task automatic complete(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v,
                          input logic f, input logic m);
    cmp_valid = 1'b1; cmp_tag = t; cmp_value = v; cmp_fault = f; cmp_misp = m;
  endtask

  task automatic t_reset();
    #2;
    chk("R1 empty", 32'(empty), 1);
    chk("R1 ready", 32'(iss_ready), 1);
    chk("R1 tag", 32'(iss_tag), 0);
    chk("R1 quiet", {29'd0, rf_we, st_req, flush}, 0);
  endtask

  task automatic t_single_alu();
    issue(ALU, 5'd5, 3'd0, "R2 first");
    step(); complete(3'd0, 32'h11, 0, 0); #2;
    chk("R4 no rf write at completion", 32'(rf_we), 0);
    step(); look_tag = 3'd0; #2;
    chk("R4 lookup done", 32'(look_done), 1);
    chk("R4 lookup value", look_value, 32'h11);
    chk("R6 alu we", 32'(rf_we), 1);
    chk("R6 alu addr", 32'(rf_addr), 5);
    chk("R6 alu data", rf_data, 32'h11);
    step(); #2;
    chk("R5 empty after retire", 32'(empty), 1);
  endtask

  task automatic t_out_of_order();
    issue(LOAD, 5'd1, 3'd1, "R2 load");
    issue(STORE, 5'd0, 3'd2, "R2 store");
    issue(BRANCH, 5'd0, 3'd3, "R2 branch");
    issue(ALU, 5'd7, 3'd4, "R2 alu");
    step(); complete(3'd4, 32'h44, 0, 0);
    step(); complete(3'd3, 32'h0, 0, 0);
    step(); complete(3'd2, 32'h5A, 0, 0); #2;
    chk("R5 head not done no write", {30'd0, rf_we, st_req}, 0);
    step(); complete(3'd1, 32'hAB, 0, 0); #2;
    chk("R7 no early store", {30'd0, rf_we, st_req}, 0);
    step(); #2;
    chk("R6 load we", 32'(rf_we), 1);
    chk("R6 load addr", 32'(rf_addr), 1);
    chk("R6 load data", rf_data, 32'hAB);
    step(); #2;
    chk("R7 store req", 32'(st_req), 1);
    chk("R7 store data", st_data, 32'h5A);
    chk("R7 store no rf", 32'(rf_we), 0);
    step(); #2;
    chk("R8 branch quiet", {29'd0, rf_we, st_req, flush}, 0);
    chk("R8 branch not empty", 32'(empty), 0);
    step(); #2;
    chk("R5 alu last we", 32'(rf_we), 1);
    chk("R5 alu last addr", 32'(rf_addr), 7);
    step(); #2;
    chk("R5 drained", 32'(empty), 1);
  endtask

  task automatic t_full_and_fault();
    for (int i = 0; i < DEPTH; i++)
      issue(ALU, 5'(i + 10), 3'(5 + i), "R2 wrap");
    step(); iss_valid = 1'b1; iss_kind = ALU; iss_dest = 5'd30;
    complete(3'd7, 32'h77, 0, 0); #2;
    chk("R3 full not ready", 32'(iss_ready), 0);
    step(); complete(3'd5, 32'h55, 0, 0);
    step(); #2;
    chk("R3 commit while full", 32'(rf_we), 1);
    chk("R3 still full", 32'(iss_ready), 0);
    step(); iss_valid = 1'b1; iss_kind = ALU; iss_dest = 5'd31;
    complete(3'd6, 32'h66, 1, 0); #2;
    chk("R3 ready after free", 32'(iss_ready), 1);
    chk("R3 refused issue left no trace", 32'(iss_tag), 5);
    step(); look_tag = 3'd7; #2;
    chk("R10 flush", 32'(flush), 1);
    chk("R10 fault kind", 32'(flush_fault), 1);
    chk("R10 no write", {30'd0, rf_we, st_req}, 0);
    step(); #2;
    chk("R10 empty", 32'(empty), 1);
    chk("R10 younger discarded", 32'(look_done), 0);
    chk("R10 tail reset", 32'(iss_tag), 0);
  endtask

  task automatic t_mispredict();
    issue(ALU, 5'd2, 3'd0, "R2 after flush");
    issue(BRANCH, 5'd0, 3'd1, "R2 br");
    issue(ALU, 5'd3, 3'd2, "R2 alu2");
    step(); complete(3'd2, 32'h33, 0, 0);
    step(); complete(3'd0, 32'h22, 0, 0);
    step(); complete(3'd1, 32'h0, 0, 1); look_tag = 3'd2; #2;
    chk("R6 commit beside completion", 32'(rf_we), 1);
    chk("R6 commit data", rf_data, 32'h22);
    step(); #2;
    chk("R9 flush", 32'(flush), 1);
    chk("R9 mispredict kind", 32'(flush_fault), 0);
    chk("R9 no write", 32'(rf_we), 0);
    step(); #2;
    chk("R9 empty", 32'(empty), 1);
    chk("R9 tag cleared", 32'(look_done), 0);
    chk("R9 tail reset", 32'(iss_tag), 0);
  endtask

  task automatic t_issue_with_commit();
    issue(ALU, 5'd4, 3'd0, "R2 r11 first");
    step(); complete(3'd0, 32'h44, 0, 0);
    step(); iss_valid = 1'b1; iss_kind = ALU; iss_dest = 5'd9; #2;
    chk("R11 commit", 32'(rf_we), 1);
    chk("R11 issue tag", 32'(iss_tag), 1);
    step(); look_tag = 3'd1; #2;
    chk("R11 occupancy kept", 32'(empty), 0);
    chk("R11 new entry pending", 32'(look_done), 0);
    complete(3'd1, 32'h99, 0, 0);
    step(); #2;
    chk("R11 second we", 32'(rf_we), 1);
    chk("R11 second data", rf_data, 32'h99);
    step(); #2;
    chk("R11 empty", 32'(empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_alu();
    t_out_of_order();
    t_full_and_fault();
    t_mispredict();
    t_issue_with_commit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule